// File: doc/BRIEF.md
# Quadrature Shift-Add Oscillator

This block produces a pair of signed samples in quadrature, sine and cosine, from two accumulators that feed each other. On each enabled sample, the sine accumulator adds an arithmetically right-shifted copy of the cosine accumulator. The cosine accumulator then subtracts a right-shifted copy of a sine value. No multiplier is involved. The runtime shift amount sets how far the phase advances per sample, so a larger shift gives a lower frequency.

The loop has no noise source, so it cannot start by itself. Reset and a synchronous load both seed it with sine at zero and cosine at a chosen amplitude.

There are two update orderings. In the growing form, both updates read the old register values; the amplitude then rises slowly and clips at the accumulator limits. In the stable form, the cosine update reads the freshly computed sine, which keeps the amplitude bounded. Each output is its accumulator shifted right by a fixed amount and registered once. A sticky flag reports that clipping has occurred.

Top module: `quad_osc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sine accumulator is set to 0 and the cosine accumulator to `INIT_AMP`. At the same edge, `sin_o` is set to 0, `cos_o` to `INIT_AMP >>> OUT_SHIFT`, and `sat_o` to 0.
- R2: When `load` is high at an edge with reset inactive, the accumulators take the same seed values as in R1 and `sat_o` clears. The output registers still sample the accumulator values from before that edge.
- R3: When `en` is low and `load` is low, both accumulators keep their values.
- R4: With `stable_mode` = 0 and `en` = 1, the updates are `sin' = sat(sin + (cos >>> k))` and `cos' = sat(cos - (sin >>> k))`, where both read the old values and `>>>` is an arithmetic shift.
- R5: With `stable_mode` = 1, the cosine update reads the new value instead: `cos' = sat(cos - (sin' >>> k))`. The amplitude then stays near `INIT_AMP`.
- R6: The shift `k` equals `shift_a` (4 bits, 1 to 15). A `shift_a` value of 0 is treated as 1.
- R7: `sat()` clamps a result that leaves the signed `ACC_W`-bit range to the largest or smallest representable value. It never wraps.
- R8: `sat_o` rises at the edge where an update clamps, and stays high until reset or load.
- R9: `sin_o` and `cos_o` equal bits `[OUT_W-1:0]` of the respective accumulator shifted arithmetically right by `OUT_SHIFT`. They are registered one cycle after the accumulator value they show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Synchronous reseed of the accumulators |
| en | input | 1 | Sample enable |
| stable_mode | input | 1 | 1 selects the bounded update ordering |
| shift_a | input | 4 | Loop shift k, 1 to 15 (0 acts as 1) |
| sin_o | output | 16 | Signed sine sample |
| cos_o | output | 16 | Signed cosine sample |
| sat_o | output | 1 | Sticky clipping indicator |

## Verification
The accumulators change at the edge where `en` or `load` is sampled. `sat_o` changes at that same edge. `sin_o` and `cos_o` show that change one edge later.

Every stimulus is driven on the falling clock edge. After each rising edge, the bench first records the pre-update accumulator values of its own integer model as the expected outputs, then advances the model by the same rules. It compares all three outputs at the following falling edge. This keeps the one-cycle output delay and the same-edge flag timing exact for every sample, including seed, hold, clamp and reseed cycles.

// File: rtl/qosc_pkg.sv
// Package: shared definitions for the quadrature shift-add oscillator.
// Assumes: nothing beyond IEEE 1800-2017.
package qosc_pkg;
    // Order in which the cosine update reads the sine value.
    typedef enum logic {
        UPD_GROWING = 1'b0,   // both updates read the old registers
        UPD_STABLE  = 1'b1    // cosine update reads the new sine
    } upd_mode_e;
endpackage

// File: rtl/qosc_sat_add.sv
// Module: qosc_sat_add - signed add or subtract that clamps to W bits.
// Assumes: a and b are two's complement W-bit values. The result is computed
// in W+1 bits, so no operand value can overflow before the clamp.
module qosc_sat_add #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] y,
    output logic                clip
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    logic signed [W:0] a_ext, b_ext, sum;

    // Sign-extend the operands, negate b when subtracting, add in W+1 bits.
    always_comb begin
        a_ext = {a[W-1], a};
        b_ext = sub ? -{b[W-1], b} : {b[W-1], b};
        sum   = a_ext + b_ext;
    end

    // Clamp when the top two bits of the wide sum disagree.
    always_comb begin
        clip = sum[W] ^ sum[W-1];
        if (!clip)       y = sum[W-1:0];
        else if (sum[W]) y = MIN_V;
        else             y = MAX_V;
    end
endmodule

// File: rtl/qosc_core.sv
// Module: qosc_core - the two cross-coupled accumulators and the sticky clip flag.
// Assumes: synchronous active-low reset; load reseeds; en gates updates.
// A shift value of 0 is promoted to 1.
module qosc_core
    import qosc_pkg::*;
#(
    parameter int ACC_W    = 32,
    parameter int SH_W     = 4,
    parameter int INIT_AMP = 268435456
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    en,
    input  upd_mode_e               mode,
    input  logic [SH_W-1:0]         shift_a,
    output logic signed [ACC_W-1:0] sin_acc,
    output logic signed [ACC_W-1:0] cos_acc,
    output logic                    sat_flag
);
    localparam logic signed [ACC_W-1:0] SEED_COS = ACC_W'(INIT_AMP);
    localparam logic signed [ACC_W-1:0] MAX_V    = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] MIN_V    = {1'b1, {(ACC_W-1){1'b0}}};

    logic [SH_W-1:0]         k_eff;
    logic signed [ACC_W-1:0] cos_sh, sin_src, sin_sh, sin_nx, cos_nx;
    logic                    clip_s, clip_c;

    // Promote a zero shift to one so the loop never adds a full copy.
    always_comb k_eff = (shift_a == '0) ? SH_W'(1) : shift_a;

    // Sine step: add the shifted cosine.
    always_comb cos_sh = cos_acc >>> k_eff;
    qosc_sat_add #(.W(ACC_W)) u_add_sin (
        .a(sin_acc), .b(cos_sh), .sub(1'b0), .y(sin_nx), .clip(clip_s)
    );

    // Cosine step: subtract the shifted old or new sine, depending on mode.
    always_comb begin
        sin_src = (mode == UPD_STABLE) ? sin_nx : sin_acc;
        sin_sh  = sin_src >>> k_eff;
    end
    qosc_sat_add #(.W(ACC_W)) u_sub_cos (
        .a(cos_acc), .b(sin_sh), .sub(1'b1), .y(cos_nx), .clip(clip_c)
    );

    // Accumulator state: seed on reset or load, advance on enable.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            sin_acc  <= '0;
            cos_acc  <= SEED_COS;
            sat_flag <= 1'b0;
        end else if (en) begin
            sin_acc  <= sin_nx;
            cos_acc  <= cos_nx;
            sat_flag <= sat_flag | clip_s | clip_c;
        end
    end

    // Marks cycles where $past refers to a post-reset sample.
    logic past_ok;
    always_ff @(posedge clk) past_ok <= rst_n;

    p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(load)) |-> (sin_acc == '0 && cos_acc == SEED_COS));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(en) && !$past(load)) |-> ($stable(sin_acc) && $stable(cos_acc)));

    p_clip_extreme_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(sat_flag)) |->
        (sin_acc == MAX_V || sin_acc == MIN_V || cos_acc == MAX_V || cos_acc == MIN_V));

    p_sat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(sat_flag) && !$past(load)) |-> sat_flag);
endmodule

// File: rtl/qosc_outreg.sv
// Module: qosc_outreg - scales one accumulator down and registers it.
// Assumes: OUT_SHIFT leaves the value within OUT_W bits (OUT_SHIFT >= ACC_W-OUT_W).
module qosc_outreg #(
    parameter int ACC_W     = 32,
    parameter int OUT_W     = 16,
    parameter int OUT_SHIFT = 16,
    parameter int RST_ACC   = 0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] q
);
    localparam logic signed [ACC_W-1:0] RST_SH = ACC_W'(RST_ACC) >>> OUT_SHIFT;

    logic signed [ACC_W-1:0] scaled;

    // Divide by 2**OUT_SHIFT with an arithmetic shift.
    always_comb scaled = acc >>> OUT_SHIFT;

    // One register stage; reset shows the scaled seed.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST_SH[OUT_W-1:0];
        else        q <= scaled[OUT_W-1:0];
    end
endmodule

// File: rtl/quad_osc.sv
// Module: quad_osc - top of the quadrature shift-add oscillator.
// Assumes: a single clock domain; all control inputs are synchronous to clk.
module quad_osc
    import qosc_pkg::*;
#(
    parameter int ACC_W     = 32,
    parameter int OUT_W     = 16,
    parameter int SH_W      = 4,
    parameter int OUT_SHIFT = ACC_W - OUT_W,
    parameter int INIT_AMP  = 268435456
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    en,
    input  logic                    stable_mode,
    input  logic [SH_W-1:0]         shift_a,
    output logic signed [OUT_W-1:0] sin_o,
    output logic signed [OUT_W-1:0] cos_o,
    output logic                    sat_o
);
    localparam int N_CH = 2;

    logic signed [ACC_W-1:0] acc   [N_CH];
    logic signed [OUT_W-1:0] q_out [N_CH];
    upd_mode_e               mode;

    // Map the plain mode pin onto the ordering enum.
    always_comb mode = stable_mode ? UPD_STABLE : UPD_GROWING;

    qosc_core #(.ACC_W(ACC_W), .SH_W(SH_W), .INIT_AMP(INIT_AMP)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .en(en), .mode(mode),
        .shift_a(shift_a), .sin_acc(acc[0]), .cos_acc(acc[1]), .sat_flag(sat_o)
    );

    // One output stage per channel: channel 0 is sine, channel 1 is cosine.
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_out
        qosc_outreg #(
            .ACC_W(ACC_W), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT),
            .RST_ACC((ch == 0) ? 0 : INIT_AMP)
        ) u_out (
            .clk(clk), .rst_n(rst_n), .acc(acc[ch]), .q(q_out[ch])
        );
    end

    assign sin_o = q_out[0];
    assign cos_o = q_out[1];

    // Marks cycles where $past refers to a post-reset sample.
    logic past_ok;
    always_ff @(posedge clk) past_ok <= rst_n;

    p_out_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (sin_o == OUT_W'($past(acc[0]) >>> OUT_SHIFT)
                  && cos_o == OUT_W'($past(acc[1]) >>> OUT_SHIFT)));
endmodule

// File: tb/quad_osc_tb_top.sv
`timescale 1ns/1ps
module quad_osc_tb_top;
    localparam int     OUT_SHIFT = 16;
    localparam longint INIT      = 268435456;
    localparam longint MAXV      = 64'sd2147483647;
    localparam longint MINV      = -64'sd2147483648;

    logic clk = 1'b0;
    logic rst_n = 1'b0, load = 1'b0, en = 1'b0, stable_mode = 1'b0;
    logic [3:0] shift_a = 4'd4;
    logic signed [15:0] sin_o, cos_o;
    logic sat_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // Reference model state.
    longint m_sin, m_cos, o_sin, o_cos;
    bit m_sat, clip_hit;
    longint peak;

    always #4 clk = ~clk;

    quad_osc dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .en(en), .stable_mode(stable_mode),
        .shift_a(shift_a), .sin_o(sin_o), .cos_o(cos_o), .sat_o(sat_o)
    );

    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clip(input longint v);
        if (v > MAXV) begin clip_hit = 1'b1; return MAXV; end
        if (v < MINV) begin clip_hit = 1'b1; return MINV; end
        return v;
    endfunction

    // One clock: advance the model at the rising edge, compare at the falling edge.
    task automatic tick(input string req);
        longint s_nx, c_nx, src;
        int k;
        @(posedge clk);
        k = (shift_a == 0) ? 1 : int'(shift_a);
        if (!rst_n) begin
            o_sin = 0; o_cos = INIT >>> OUT_SHIFT;
            m_sin = 0; m_cos = INIT; m_sat = 1'b0;
        end else begin
            o_sin = m_sin >>> OUT_SHIFT; o_cos = m_cos >>> OUT_SHIFT;
            if (load) begin
                m_sin = 0; m_cos = INIT; m_sat = 1'b0;
            end else if (en) begin
                clip_hit = 1'b0;
                s_nx = clip(m_sin + (m_cos >>> k));
                src  = stable_mode ? s_nx : m_sin;
                c_nx = clip(m_cos - (src >>> k));
                m_sin = s_nx; m_cos = c_nx;
                m_sat = m_sat | clip_hit;
            end
        end
        @(negedge clk);
        check({req, " sin_o"}, longint'(sin_o) == o_sin, longint'(sin_o), o_sin);
        check({req, " cos_o"}, longint'(cos_o) == o_cos, longint'(cos_o), o_cos);
        check({req, " sat_o"}, sat_o == m_sat, longint'(sat_o), longint'(m_sat));
    endtask

    task automatic t_reset;  // R1
        rst_n = 1'b0; tick("R1"); tick("R1");
        check("R1 cos seed", longint'(cos_o) == 4096, longint'(cos_o), 4096);
        rst_n = 1'b1;
    endtask

    task automatic t_hold;  // R3
        en = 1'b0;
        for (int i = 0; i < 4; i++) tick("R3");
        en = 1'b1; stable_mode = 1'b0; shift_a = 4'd3;
        for (int i = 0; i < 6; i++) begin en = i[0]; tick("R3"); end
        en = 1'b0; tick("R3"); tick("R3");
    endtask

    task automatic t_growing;  // R4 R9
        load = 1'b1; tick("R2"); load = 1'b0;
        stable_mode = 1'b0; shift_a = 4'd4; en = 1'b1;
        for (int i = 0; i < 60; i++) tick("R4");
        en = 1'b0; tick("R9"); tick("R9");
    endtask

    task automatic t_stable;  // R5
        load = 1'b1; tick("R2"); load = 1'b0;
        stable_mode = 1'b1; shift_a = 4'd3; en = 1'b1; peak = 0;
        for (int i = 0; i < 200; i++) begin
            tick("R5");
            if (o_cos > peak) peak = o_cos;
            check("R5 bound", longint'(cos_o) < 4400 && longint'(cos_o) > -4400, longint'(cos_o), 4400);
        end
        en = 1'b0; tick("R5");
    endtask

    task automatic t_shift;  // R6
        load = 1'b1; tick("R2"); load = 1'b0;
        stable_mode = 1'b0; shift_a = 4'd0; en = 1'b1;
        for (int i = 0; i < 8; i++) tick("R6");
        shift_a = 4'd15;
        for (int i = 0; i < 8; i++) tick("R6");
        en = 1'b0; tick("R6");
    endtask

    task automatic t_sat;  // R7 R8 R2
        load = 1'b1; tick("R2"); load = 1'b0;
        stable_mode = 1'b0; shift_a = 4'd1; en = 1'b1;
        for (int i = 0; i < 40; i++) tick("R7");
        en = 1'b0; tick("R7"); tick("R7");
        check("R8 flag set", sat_o == 1'b1, longint'(sat_o), 1);
        check("R7 clamp seen", o_sin == 32767 || o_sin == -32768 || o_cos == 32767 || o_cos == -32768,
              o_sin, 32767);
        stable_mode = 1'b1; shift_a = 4'd8; en = 1'b1;
        for (int i = 0; i < 5; i++) tick("R8");
        en = 1'b0; load = 1'b1; tick("R2"); load = 1'b0;
        check("R2 flag cleared", sat_o == 1'b0, longint'(sat_o), 0);
        tick("R2");
        check("R2 cos after load", longint'(cos_o) == 4096, longint'(cos_o), 4096);
    endtask

    initial begin
        t_reset();
        t_hold();
        t_growing();
        t_stable();
        t_shift();
        t_sat();
        rst_n = 1'b0; tick("R1"); rst_n = 1'b1; tick("R1");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule